// File: doc/BRIEF.md
# Bidirectional DES Round-Key Generator

This block produces DES round keys one at a time, in step with a cipher datapath that consumes one key per round. No round keys are stored. A 64-bit key is reduced to 56 bits and split into two 28-bit rotating halves. Each round key is a 48-bit selection taken from the current halves. An advance strobe moves the halves on by one round.

The rotation runs left for encryption, which gives keys 1 to 16 in order. It runs right for decryption, which gives keys 16 down to 1. The cipher can therefore switch to a new key, or to the other direction, by loading once. Nothing has to be precomputed first.

Control is a three-state machine:
- **ST_IDLE** is the state after reset, before any key has been loaded.
- **ST_RUN** means a round key is being presented.
- **ST_DONE** is entered after the last key has been consumed.

Transitions:
- A load moves the machine from any state to ST_RUN.
- An advance while in ST_RUN at index 15 moves it to ST_DONE.
- Every other case holds the current state.

Top module: `des_round_key_gen`

## Requirements
- R1: After reset, `valid_o` is 0, `round_o` is 0 and `rkey_o` is 0.
- R2: When `load_i` is 1 at a clock edge, then after that edge `valid_o` is 1, `round_o` is 0, and the direction given by `decrypt_i` is latched (0 means encrypt, 1 means decrypt).
- R3: In encrypt mode, the key at `round_o` = r is the standard DES subkey number r+1. Each accepted `step_i` pulse advances `round_o` by one.
- R4: In decrypt mode, the key at `round_o` = r is the standard DES subkey number 16-r. The first key is the permuted loaded key with no rotation.
- R5: Key bits `key_i[0]`, `key_i[8]`, ..., `key_i[56]` (the parity bits, bit 1 of the standard numbering being `key_i[63]`) have no effect on any round key.
- R6: A `step_i` while `round_o` is 15 clears `valid_o`. While `valid_o` is 0, `step_i` changes neither `rkey_o` nor `round_o`.
- R7: `load_i` takes priority over `step_i`, and a load in mid-sequence restarts at index 0 with the new key.
- R8: With neither `load_i` nor `step_i` asserted, `rkey_o`, `round_o` and `valid_o` hold.
- R9: `decrypt_i` is sampled only on a load. Changing it mid-sequence has no effect on the keys produced.
- R10: The round key is laid out MSB-first: selected bit 1 of the standard numbering appears on `rkey_o[47]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| key_i | input | 64 | Cipher key including parity bits, standard bit 1 at bit 63 |
| load_i | input | 1 | Load key and restart at index 0 |
| decrypt_i | input | 1 | Direction for the next load: 0 encrypt, 1 decrypt |
| step_i | input | 1 | Advance to the next round key |
| rkey_o | output | 48 | Current round key |
| round_o | output | 4 | Index of the current key in output order (0..15) |
| valid_o | output | 1 | A loaded sequence is in progress |

## Verification
The assertions check these rules on every cycle:
- a load restarts at index 0 with `valid_o` set;
- an accepted step increments the index;
- the last step ends the sequence;
- outputs hold with no strobe;
- a step outside a sequence is inert.

Only the bench's scenarios can show the key values themselves. It compares every one of the 16 keys in both directions against an independent cumulative-shift model, including a published key vector. It also runs the parity-bit, mid-run-direction and mid-run-reload cases.

// File: rtl/des_ks_pkg.sv
package des_ks_pkg;
    localparam int KEY_W  = 64;
    localparam int CD_W   = 56;
    localparam int HALF_W = CD_W / 2;
    localparam int RK_W   = 48;
    localparam int ROUNDS = 16;
    localparam int RND_W  = $clog2(ROUNDS);

    // Source positions, standard 1-based MSB-first numbering.
    localparam int PC1_TAB [CD_W] = '{
        57,49,41,33,25,17, 9, 1,58,50,42,34,26,18,
        10, 2,59,51,43,35,27,19,11, 3,60,52,44,36,
        63,55,47,39,31,23,15, 7,62,54,46,38,30,22,
        14, 6,61,53,45,37,29,21,13, 5,28,20,12, 4};

    localparam int PC2_TAB [RK_W] = '{
        14,17,11,24, 1, 5, 3,28,15, 6,21,10,
        23,19,12, 4,26, 8,16, 7,27,20,13, 2,
        41,52,31,37,47,55,30,40,51,45,33,48,
        44,49,39,56,34,53,46,42,50,36,29,32};

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_RUN,
        ST_DONE
    } ks_state_e;

    // Round index (0-based) -> shift by two? Single shifts at 0,1,8,15.
    function automatic logic shift_two(input int idx);
        return !(idx == 0 || idx == 1 || idx == 8 || idx == ROUNDS - 1);
    endfunction
endpackage

// File: rtl/des_ks_pc1.sv
module des_ks_pc1
    import des_ks_pkg::*;
(
    input  logic [KEY_W-1:0] key_i,
    output logic [CD_W-1:0]  cd_o
);
    localparam int NBYTES = KEY_W / 8;

    logic [NBYTES-1:0] parity_unused;

    for (genvar i = 0; i < CD_W; i++) begin : g_sel
        assign cd_o[CD_W-1-i] = key_i[KEY_W - PC1_TAB[i]];
    end

    for (genvar b = 0; b < NBYTES; b++) begin : g_par
        assign parity_unused[b] = key_i[8*b];
    end
endmodule

// File: rtl/des_ks_pc2.sv
module des_ks_pc2
    import des_ks_pkg::*;
(
    input  logic [CD_W-1:0] cd_i,
    output logic [RK_W-1:0] rk_o
);
    for (genvar i = 0; i < RK_W; i++) begin : g_sel
        assign rk_o[RK_W-1-i] = cd_i[CD_W - PC2_TAB[i]];
    end
endmodule

// File: rtl/des_ks_rot.sv
module des_ks_rot #(
    parameter int W = 28
) (
    input  logic [W-1:0] d_i,
    input  logic         right_i,
    input  logic         two_i,
    output logic [W-1:0] q_o
);
    always_comb begin
        unique case ({right_i, two_i})
            2'b00:   q_o = {d_i[W-2:0], d_i[W-1]};
            2'b01:   q_o = {d_i[W-3:0], d_i[W-1:W-2]};
            2'b10:   q_o = {d_i[0], d_i[W-1:1]};
            default: q_o = {d_i[1:0], d_i[W-1:2]};
        endcase
    end
endmodule

// File: rtl/des_ks_ctrl.sv
module des_ks_ctrl
    import des_ks_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic             step_i,
    input  logic             decrypt_i,
    output logic             run_o,
    output logic             adv_o,
    output logic             dec_o,
    output logic [RND_W-1:0] round_o
);
    localparam logic [RND_W-1:0] LAST = RND_W'(ROUNDS - 1);

    ks_state_e state_q, state_d;
    logic      last;

    assign last = (round_o == LAST);

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (load_i) state_d = ST_RUN;
            ST_RUN: begin
                if (load_i)              state_d = ST_RUN;
                else if (step_i && last) state_d = ST_DONE;
            end
            ST_DONE: if (load_i) state_d = ST_RUN;
            default: state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        run_o = (state_q == ST_RUN);
        adv_o = run_o && step_i && !load_i && !last;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            round_o <= '0;
            dec_o   <= 1'b0;
        end else if (load_i) begin
            round_o <= '0;
            dec_o   <= decrypt_i;
        end else if (adv_o) begin
            round_o <= round_o + 1'b1;
        end
    end
endmodule

// File: rtl/des_round_key_gen.sv
module des_round_key_gen
    import des_ks_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [63:0]      key_i,
    input  logic             load_i,
    input  logic             decrypt_i,
    input  logic             step_i,
    output logic [47:0]      rkey_o,
    output logic [3:0]       round_o,
    output logic             valid_o
);
    logic [CD_W-1:0]  pc1_cd, cd_q, rot_src, rot_out;
    logic             run, adv, dec_mode, rot_right, rot_two;
    logic [RND_W-1:0] rnd;
    int               sh_idx;

    des_ks_pc1 u_pc1 (.key_i(key_i), .cd_o(pc1_cd));

    des_ks_ctrl u_ctrl (
        .clk(clk), .rst_n(rst_n), .load_i(load_i), .step_i(step_i),
        .decrypt_i(decrypt_i), .run_o(run), .adv_o(adv),
        .dec_o(dec_mode), .round_o(rnd)
    );

    // Encrypt: next index's left shift. Decrypt: undo the current key's shift.
    always_comb begin
        sh_idx    = dec_mode ? (ROUNDS - 1 - int'(rnd)) : (int'(rnd) + 1);
        rot_src   = load_i ? pc1_cd : cd_q;
        rot_right = load_i ? 1'b0 : dec_mode;
        rot_two   = load_i ? 1'b0 : shift_two(sh_idx);
    end

    for (genvar h = 0; h < 2; h++) begin : g_half
        des_ks_rot #(.W(HALF_W)) u_rot (
            .d_i    (rot_src[h*HALF_W +: HALF_W]),
            .right_i(rot_right),
            .two_i  (rot_two),
            .q_o    (rot_out[h*HALF_W +: HALF_W])
        );
    end

    always_ff @(posedge clk) begin
        if (!rst_n)      cd_q <= '0;
        else if (load_i) cd_q <= decrypt_i ? pc1_cd : rot_out;
        else if (adv)    cd_q <= rot_out;
    end

    des_ks_pc2 u_pc2 (.cd_i(cd_q), .rk_o(rkey_o));

    assign round_o = rnd;
    assign valid_o = run;
endmodule

// File: rtl/des_ks_checker.sv
module des_ks_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        load_i,
    input logic        step_i,
    input logic [47:0] rkey_o,
    input logic [3:0]  round_o,
    input logic        valid_o
);
    // R2 / R7
    p_load_restart_r2: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> (valid_o && round_o == 4'd0));

    // R3
    p_step_advance_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && step_i && !load_i && round_o != 4'd15)
        |=> (valid_o && round_o == $past(round_o) + 4'd1));

    // R6
    p_last_step_ends_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && step_i && !load_i && round_o == 4'd15) |=> !valid_o);

    p_inert_when_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!valid_o && !load_i)
        |=> (!valid_o && $stable(rkey_o) && $stable(round_o)));

    // R8
    p_hold_no_strobe_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && !step_i)
        |=> ($stable(rkey_o) && $stable(round_o) && $stable(valid_o)));
endmodule

bind des_round_key_gen des_ks_checker u_chk (
    .clk(clk), .rst_n(rst_n), .load_i(load_i), .step_i(step_i),
    .rkey_o(rkey_o), .round_o(round_o), .valid_o(valid_o)
);

// File: tb/des_round_key_gen_tb_top.sv
module des_round_key_gen_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [63:0] key_i = '0;
    logic        load_i = 1'b0, decrypt_i = 1'b0, step_i = 1'b0;
    logic [47:0] rkey_o;
    logic [3:0]  round_o;
    logic        valid_o;

    int vectors = 0;
    int miscompares = 0;

    always #5 clk = ~clk;

    des_round_key_gen dut_i (.*);

    localparam int TB_PC1 [56] = '{
        57,49,41,33,25,17, 9, 1,58,50,42,34,26,18,
        10, 2,59,51,43,35,27,19,11, 3,60,52,44,36,
        63,55,47,39,31,23,15, 7,62,54,46,38,30,22,
        14, 6,61,53,45,37,29,21,13, 5,28,20,12, 4};
    localparam int TB_PC2 [48] = '{
        14,17,11,24, 1, 5, 3,28,15, 6,21,10,
        23,19,12, 4,26, 8,16, 7,27,20,13, 2,
        41,52,31,37,47,55,30,40,51,45,33,48,
        44,49,39,56,34,53,46,42,50,36,29,32};

    // Subkey n (1..16) from cumulative left rotation of the permuted key.
    function automatic logic [47:0] ref_key(input logic [63:0] k, input int n);
        logic [27:0] c, d;
        logic [55:0] cd;
        logic [47:0] rk;
        int total = 0;
        for (int i = 0; i < 28; i++) begin
            c[27-i] = k[64 - TB_PC1[i]];
            d[27-i] = k[64 - TB_PC1[i+28]];
        end
        for (int j = 1; j <= n; j++)
            total += (j == 1 || j == 2 || j == 9 || j == 16) ? 1 : 2;
        for (int s = 0; s < total; s++) begin
            c = {c[26:0], c[27]};
            d = {d[26:0], d[27]};
        end
        cd = {c, d};
        for (int i = 0; i < 48; i++) rk[47-i] = cd[56 - TB_PC2[i]];
        return rk;
    endfunction

    task automatic chk(input string req, input logic [63:0] got, input logic [63:0] exp);
        vectors++;
        if (got !== exp) begin
            miscompares++;
            $display("FAIL %s: got %h expected %h at %0t", req, got, exp, $time);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic load(input logic [63:0] k, input logic dec, input logic with_step);
        key_i = k; decrypt_i = dec; load_i = 1'b1; step_i = with_step;
        tick();
        load_i = 1'b0; step_i = 1'b0;
    endtask

    task automatic step();
        step_i = 1'b1;
        tick();
        step_i = 1'b0;
    endtask

    function automatic logic [47:0] exp_at(input logic [63:0] k, input logic dec, input int r);
        return dec ? ref_key(k, 16 - r) : ref_key(k, r + 1);
    endfunction

    // Full run; parity noise and direction noise applied to the live inputs.
    task automatic run_seq(input logic [63:0] k, input logic dec, input bit noisy);
        logic [63:0] ld = k;
        if (noisy) ld = k ^ ({$urandom, $urandom} & 64'h0101010101010101);
        load(ld, dec, 1'b0);
        chk("R2 valid after load", {63'd0, valid_o}, 64'd1);
        chk("R2 round after load", {60'd0, round_o}, 64'd0);
        chk(dec ? "R4 key r0" : "R3 key r0", {16'd0, rkey_o}, {16'd0, exp_at(k, dec, 0)});
        for (int r = 1; r < 16; r++) begin
            int gap = $urandom_range(0, 2);
            for (int g = 0; g < gap; g++) begin
                if (noisy) decrypt_i = $urandom_range(0, 1);   // R9
                tick();
                chk("R8 hold key", {16'd0, rkey_o}, {16'd0, exp_at(k, dec, r - 1)});
            end
            if (noisy) begin
                decrypt_i = $urandom_range(0, 1);
                key_i     = {$urandom, $urandom};
            end
            step();
            chk("R3 round index", {60'd0, round_o}, 64'(r));
            chk(noisy ? "R5/R9 key" : (dec ? "R4 key" : "R3 key"),
                {16'd0, rkey_o}, {16'd0, exp_at(k, dec, r)});
        end
        step();
        chk("R6 valid cleared", {63'd0, valid_o}, 64'd0);
        step();
        chk("R6 round held", {60'd0, round_o}, 64'd15);
        chk("R6 key held", {16'd0, rkey_o}, {16'd0, exp_at(k, dec, 15)});
    endtask

    initial begin
        void'($urandom(32'h5EED_0D35));
        repeat (3) tick();
        chk("R1 valid", {63'd0, valid_o}, 64'd0);
        chk("R1 round", {60'd0, round_o}, 64'd0);
        chk("R1 key", {16'd0, rkey_o}, 64'd0);
        rst_n = 1'b1;
        tick();
        step();
        chk("R6 idle step valid", {63'd0, valid_o}, 64'd0);
        chk("R6 idle step key", {16'd0, rkey_o}, 64'd0);

        // Published vector, MSB-first layout.
        load(64'h133457799BBCDFF1, 1'b0, 1'b0);
        chk("R10 first enc key", {16'd0, rkey_o}, 64'h1B02EFFC7072);
        load(64'h133457799BBCDFF1, 1'b1, 1'b0);
        chk("R4 first dec key", {16'd0, rkey_o}, 64'hCB3D8B0E17F5);

        run_seq(64'h0123456789ABCDEF, 1'b0, 1'b0);
        run_seq(64'h0123456789ABCDEF, 1'b1, 1'b0);
        run_seq(64'hFFFFFFFFFFFFFFFF, 1'b1, 1'b0);

        // R7: reload in mid-sequence with a simultaneous step.
        load(64'hA5A5A5A5C3C3C3C3, 1'b0, 1'b0);
        repeat (5) step();
        load(64'h0F1E2D3C4B5A6978, 1'b1, 1'b1);
        chk("R7 round restart", {60'd0, round_o}, 64'd0);
        chk("R7 new key", {16'd0, rkey_o}, {16'd0, ref_key(64'h0F1E2D3C4B5A6978, 16)});

        for (int n = 0; n < 30; n++) begin
            logic [63:0] k = {$urandom, $urandom};
            run_seq(k, n[0], 1'b0);
            run_seq(k, ~n[0], 1'b1);
        end

        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        #5_000_000;
        miscompares++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule